// File: doc/BRIEF.md
# STM-1 Frame Aligner and Section Overhead Marker

This block sits at the receive side of a 155.52 Mbit/s synchronous line interface, after the serial-to-parallel stage. It takes one byte per clock, qualified by a valid strobe. It hunts for the six-byte framing word: three bytes of 0xF6 followed by three bytes of 0x28. Once it finds the word, it locks a 9-row by 270-column position grid to it and follows alignment from frame to frame.

Every accepted byte leaves the block one clock later. With it come its row and column, a marker for section overhead bytes in the regenerator rows and a marker for those in the multiplex rows, and a single-cycle start-of-frame pulse. Two alignment status outputs go with the stream: an in-frame level and a latched loss-of-frame alarm. Downstream descrambling, pointer processing and payload mapping use these markers to pick bytes out of the stream.

The block acquires alignment after two framing words found 2430 bytes apart. It rides through up to three errored framing words in a row. A fourth errored word drops alignment, raises the alarm and restarts the hunt.

Top module: `stm1_framer`

## Requirements
- R1: While hunting, the accepted byte that completes the sequence 0xF6 0xF6 0xF6 0x28 0x28 0x28 (the last six accepted bytes, oldest first) is given row 0, column 5. Counting continues from that position with the next byte.
- R2: Row (0..8) and column (0..269) advance only on accepted bytes, column first, wrapping 269→0 with a row increment and row 8→0. They keep running freely while hunting or confirming.
- R3: From the confirming state, a correct framing word that ends at row 0 column 5 (2430 bytes after the previous one) raises in_frame. The rise shows with that byte's outputs. A single framing word is not enough.
- R4: In the confirming state, a wrong framing word at the expected position returns the block to hunting without raising in_frame.
- R5: While in frame, up to three consecutive errored framing words leave in_frame high and loss_of_frame low. A correct word resets the error count.
- R6: The fourth consecutive errored framing word drops in_frame and sets loss_of_frame with that byte's outputs. loss_of_frame is 0 after reset and clears only when in_frame next rises.
- R7: rs_oh marks bytes in columns 0..8 of rows 0..2, and ms_oh marks columns 0..8 of rows 4..8. Row 3 and columns 9..269 get neither. Both stay low unless in_frame is high for that byte.
- R8: sof is high for exactly the byte at row 0 column 0 while in frame, so once per aligned frame.
- R9: out_valid and out_byte repeat in_valid and in_byte one clock later. Row, column and flags belong to that same byte. On cycles without a byte, row, column and out_byte hold, and sof, rs_oh and ms_oh are low.
- R10: During and just after reset all outputs are 0, with row 0 and column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Received line byte |
| out_valid | output | 1 | Delayed byte strobe |
| out_byte | output | 8 | Received byte, one clock late |
| in_frame | output | 1 | Alignment held |
| loss_of_frame | output | 1 | Latched alarm after repeated framing errors |
| row | output | 4 | Row of out_byte, 0..8 |
| col | output | 9 | Column of out_byte, 0..269 |
| rs_oh | output | 1 | out_byte is regenerator section overhead |
| ms_oh | output | 1 | out_byte is multiplex section overhead |
| sof | output | 1 | out_byte is the first framing byte of an aligned frame |

## Verification
Every result of this block is due exactly one clock after the byte that causes it is accepted. This includes the position fields, the overhead markers and the pulse, and also the in_frame and loss_of_frame changes decided on the byte at row 0 column 5. Idle cycles must leave position and data unchanged. The bench drives each byte at the falling edge and advances its behavioural model by that byte. It then compares every output one nanosecond after the next rising edge, so the sample and the expected value refer to the same byte. Scenario checks add an idle cycle before sampling, so the last byte's results are stable when read.

// File: rtl/stm1_framer_pkg.sv
// Package: shared alignment state type for the STM-1 frame aligner.
// Assumes nothing beyond IEEE 1800-2017 enums.
package stm1_framer_pkg;

    // Alignment states: hunting for the word, confirming it, and locked.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } align_state_t;

endpackage

// File: rtl/stm1_framer_window.sv
// Module: sliding comparison window over the last PAT_LEN accepted bytes.
// It keeps PAT_LEN-1 older bytes in a shift register and compares them,
// together with the byte now presented, against A1_CNT copies of A1_BYTE
// followed by A2_CNT copies of A2_BYTE (oldest first).
// Assumes PAT_LEN >= 2; match is combinational on the current byte.
module stm1_framer_window #(
    parameter int          DATA_W  = 8,
    parameter int          A1_CNT  = 3,
    parameter int          A2_CNT  = 3,
    parameter logic [7:0]  A1_BYTE = 8'hF6,
    parameter logic [7:0]  A2_BYTE = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] byte_in,
    output logic              match
);
    localparam int PAT_LEN = A1_CNT + A2_CNT;
    localparam int HIST_N  = PAT_LEN - 1;

    logic [HIST_N-1:0][DATA_W-1:0] hist_q;   // index 0 is the newest
    logic [PAT_LEN-1:0]            hit;

    // Shift the accepted byte into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_N-2:0], byte_in};
        end
    end

    // One comparator per window slot; slot PAT_LEN-1 is the current byte.
    for (genvar k = 0; k < PAT_LEN; k++) begin : g_slot
        localparam logic [DATA_W-1:0] EXP = (k < A1_CNT) ? DATA_W'(A1_BYTE)
                                                         : DATA_W'(A2_BYTE);
        if (k == PAT_LEN - 1) begin : g_cur
            assign hit[k] = (byte_in == EXP);
        end else begin : g_old
            assign hit[k] = (hist_q[PAT_LEN-2-k] == EXP);
        end
    end

    assign match = &hit;

endmodule

// File: rtl/stm1_framer_grid.sv
// Module: row/column position counter of the frame grid.
// q outputs hold the position the next accepted byte will take, and cur
// outputs give the position of the byte accepted this cycle. A load forces
// that byte to row 0, column LOAD_COL. Counting happens on step only.
// Assumes ROWS >= 2 and COLS > LOAD_COL.
module stm1_framer_grid #(
    parameter int ROWS     = 9,
    parameter int COLS     = 270,
    parameter int LOAD_COL = 5,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col
);
    // Position of the byte being accepted now.
    always_comb begin
        if (load) begin
            cur_row = '0;
            cur_col = COL_W'(LOAD_COL);
        end else begin
            cur_row = row_q;
            cur_col = col_q;
        end
    end

    // Advance past the accepted byte, wrapping column then row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (step) begin
            if (cur_col == COL_W'(COLS - 1)) begin
                col_q <= '0;
                row_q <= (cur_row == ROW_W'(ROWS - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end

endmodule

// File: rtl/stm1_framer_sync.sv
// Module: alignment state machine with confirm and loss counters.
// Hunting: a window match loads the grid and starts confirmation. At the
// check position a match counts toward CONFIRM_FRAMES; a miss while
// confirming goes back to hunting. Locked: LOSS_FRAMES misses in a row
// drop lock and set the latched loss alarm, which clears on relock.
// Assumes at_check is derived from the registered grid position.
module stm1_framer_sync
    import stm1_framer_pkg::*;
#(
    parameter int CONFIRM_FRAMES = 2,
    parameter int LOSS_FRAMES    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         match,
    input  logic         at_check,
    output logic         load,
    output align_state_t state_q,
    output align_state_t state_d,
    output logic         lof_q
);
    localparam int GOOD_W = $clog2(CONFIRM_FRAMES + 1);
    localparam int BAD_W  = $clog2(LOSS_FRAMES + 1);

    logic [GOOD_W-1:0] good_q, good_d;
    logic [BAD_W-1:0]  bad_q,  bad_d;
    logic              lof_d;

    // Next-state and counter decisions for the byte accepted now.
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        bad_d   = bad_q;
        lof_d   = lof_q;
        load    = 1'b0;
        case (state_q)
            ST_HUNT: begin
                if (step && match) begin
                    load   = 1'b1;
                    good_d = GOOD_W'(1);
                    bad_d  = '0;
                    if (CONFIRM_FRAMES <= 1) begin
                        state_d = ST_LOCKED;
                        lof_d   = 1'b0;
                    end else begin
                        state_d = ST_CONFIRM;
                    end
                end
            end
            ST_CONFIRM: begin
                if (step && at_check) begin
                    if (!match) begin
                        state_d = ST_HUNT;
                    end else if (good_q == GOOD_W'(CONFIRM_FRAMES - 1)) begin
                        state_d = ST_LOCKED;
                        lof_d   = 1'b0;
                        bad_d   = '0;
                    end else begin
                        good_d = good_q + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (step && at_check) begin
                    if (match) begin
                        bad_d = '0;
                    end else if (bad_q == BAD_W'(LOSS_FRAMES - 1)) begin
                        state_d = ST_HUNT;
                        lof_d   = 1'b1;
                        bad_d   = '0;
                    end else begin
                        bad_d = bad_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Register state, counters and the loss alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
            lof_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
            bad_q   <= bad_d;
            lof_q   <= lof_d;
        end
    end

endmodule

// File: rtl/stm1_framer_oh_class.sv
// Module: classifies a grid position into overhead kind and frame start.
// Columns below OH_COLS are overhead. Rows below RS_ROWS are regenerator
// overhead, row PTR_ROW is the pointer row (neither), and later rows are
// multiplex overhead. All outputs are forced low when not aligned.
// Assumes RS_ROWS <= PTR_ROW < ROWS.
module stm1_framer_oh_class #(
    parameter int ROWS    = 9,
    parameter int OH_COLS = 9,
    parameter int RS_ROWS = 3,
    parameter int PTR_ROW = 3,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 9
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             aligned,
    output logic             rs_oh,
    output logic             ms_oh,
    output logic             sof
);
    logic in_oh_cols;

    // Decode the position against the overhead layout.
    always_comb begin
        in_oh_cols = (col < COL_W'(OH_COLS));
        rs_oh = aligned && in_oh_cols && (row < ROW_W'(RS_ROWS));
        ms_oh = aligned && in_oh_cols && (row > ROW_W'(PTR_ROW))
                        && (row < ROW_W'(ROWS));
        sof   = aligned && (row == '0) && (col == '0);
    end

endmodule

// File: rtl/stm1_framer.sv
// Module: STM-1 frame aligner and section overhead marker (top).
// It accepts one byte per clock when in_valid is high, finds and tracks the
// framing word, and presents each byte one clock later with its grid
// position, overhead markers and start-of-frame pulse.
// Assumes bytes arrive already octet-aligned and unscrambled framing bytes.
module stm1_framer #(
    parameter int          ROWS           = 9,
    parameter int          COLS           = 270,
    parameter int          OH_COLS        = 9,
    parameter int          RS_ROWS        = 3,
    parameter int          PTR_ROW        = 3,
    parameter int          A1_CNT         = 3,
    parameter int          A2_CNT         = 3,
    parameter logic [7:0]  A1_BYTE        = 8'hF6,
    parameter logic [7:0]  A2_BYTE        = 8'h28,
    parameter int          CONFIRM_FRAMES = 2,
    parameter int          LOSS_FRAMES    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       in_frame,
    output logic       loss_of_frame,
    output logic [3:0] row,
    output logic [8:0] col,
    output logic       rs_oh,
    output logic       ms_oh,
    output logic       sof
);
    import stm1_framer_pkg::*;

    localparam int ROW_W     = 4;
    localparam int COL_W     = 9;
    localparam int PAT_LEN   = A1_CNT + A2_CNT;
    localparam int CHECK_COL = PAT_LEN - 1;

    logic             match;
    logic             load;
    logic             at_check;
    logic [ROW_W-1:0] row_q, cur_row;
    logic [COL_W-1:0] col_q, cur_col;
    align_state_t     state_q, state_d;
    logic             lof_q;
    logic             rs_c, ms_c, sof_c;

    stm1_framer_window #(
        .DATA_W (8),
        .A1_CNT (A1_CNT),
        .A2_CNT (A2_CNT),
        .A1_BYTE(A1_BYTE),
        .A2_BYTE(A2_BYTE)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(in_valid),
        .byte_in (in_byte),
        .match   (match)
    );

    stm1_framer_grid #(
        .ROWS    (ROWS),
        .COLS    (COLS),
        .LOAD_COL(CHECK_COL),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W)
    ) u_grid (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (in_valid),
        .load   (load),
        .row_q  (row_q),
        .col_q  (col_q),
        .cur_row(cur_row),
        .cur_col(cur_col)
    );

    // Check position taken from the registered grid to avoid a load loop.
    assign at_check = (row_q == '0) && (col_q == COL_W'(CHECK_COL));

    stm1_framer_sync #(
        .CONFIRM_FRAMES(CONFIRM_FRAMES),
        .LOSS_FRAMES   (LOSS_FRAMES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_valid),
        .match   (match),
        .at_check(at_check),
        .load    (load),
        .state_q (state_q),
        .state_d (state_d),
        .lof_q   (lof_q)
    );

    stm1_framer_oh_class #(
        .ROWS   (ROWS),
        .OH_COLS(OH_COLS),
        .RS_ROWS(RS_ROWS),
        .PTR_ROW(PTR_ROW),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_class (
        .row    (cur_row),
        .col    (cur_col),
        .aligned(state_d == ST_LOCKED),
        .rs_oh  (rs_c),
        .ms_oh  (ms_c),
        .sof    (sof_c)
    );

    // Output stage: one clock of delay, byte data and position held on gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            row       <= '0;
            col       <= '0;
            rs_oh     <= 1'b0;
            ms_oh     <= 1'b0;
            sof       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            rs_oh     <= in_valid && rs_c;
            ms_oh     <= in_valid && ms_c;
            sof       <= in_valid && sof_c;
            if (in_valid) begin
                out_byte <= in_byte;
                row      <= cur_row;
                col      <= cur_col;
            end
        end
    end

    assign in_frame      = (state_q == ST_LOCKED);
    assign loss_of_frame = lof_q;

endmodule

// File: rtl/stm1_framer_chk.sv
// Module: property checker for the frame aligner, bound to the top.
// Watches only the top-level outputs; assumes synchronous active-low reset.
module stm1_framer_chk #(
    parameter int ROWS      = 9,
    parameter int COLS      = 270,
    parameter int CHECK_COL = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       in_frame,
    input logic       loss_of_frame,
    input logic [3:0] row,
    input logic [8:0] col,
    input logic       rs_oh,
    input logic       ms_oh,
    input logic       sof
);
    // R2: position stays inside the grid
    a_r2_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (row < 4'(ROWS)) && (col < 9'(COLS)));

    // R9: position holds on cycles without a byte
    a_r9_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(row) && $stable(col)));

    // R9: markers only accompany a delivered byte
    a_r9_flags_need_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (sof || rs_oh || ms_oh) |-> out_valid);

    // R7: overhead markers only while aligned, never both
    a_r7_oh_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_oh || ms_oh) |-> in_frame);
    a_r7_oh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rs_oh, ms_oh}) <= 1);

    // R8: start pulse at origin of grid, single cycle
    a_r8_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (in_frame && row == 4'd0 && col == 9'd0));
    a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R3: alignment is gained only on the check byte
    a_r3_gain_at_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (out_valid && row == 4'd0 && col == 9'(CHECK_COL)));

    // R6: alarm excludes alignment and rises only as alignment falls
    a_r6_lof_excl: assert property (@(posedge clk) disable iff (!rst_n)
        loss_of_frame |-> !in_frame);
    a_r6_lof_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_of_frame) |-> $fell(in_frame));
    a_r6_lof_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loss_of_frame) |-> $rose(in_frame));

endmodule

bind stm1_framer stm1_framer_chk #(
    .ROWS     (ROWS),
    .COLS     (COLS),
    .CHECK_COL(A1_CNT + A2_CNT - 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .in_frame     (in_frame),
    .loss_of_frame(loss_of_frame),
    .row          (row),
    .col          (col),
    .rs_oh        (rs_oh),
    .ms_oh        (ms_oh),
    .sof          (sof)
);

// File: tb/test_stm1_framer.sv
// Bench: behavioural reference model of the aligner, compared every clock.
module test_stm1_framer;
    localparam int FRAME_BYTES = 2430;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, in_frame, loss_of_frame, rs_oh, ms_oh, sof;
    logic [7:0] out_byte;
    logic [3:0] row;
    logic [8:0] col;

    stm1_framer i_stm1_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .in_frame(in_frame),
        .loss_of_frame(loss_of_frame), .row(row), .col(col),
        .rs_oh(rs_oh), .ms_oh(ms_oh), .sof(sof)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit mon_on = 0;
    int sof_seen = 0, rs_seen = 0, ms_seen = 0;

    // Reference model state
    logic [7:0] hist[$];
    int m_row = 0, m_col = 0, m_state = 0, m_good = 0, m_bad = 0;
    bit m_lof = 0;
    bit e_valid = 0, e_inf = 0, e_lof = 0, e_rs = 0, e_ms = 0, e_sof = 0;
    int e_byte = 0, e_row = 0, e_col = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one accepted byte (states: 0 hunt, 1 confirm, 2 locked).
    function automatic void model_step(input logic [7:0] b);
        int pr, pc;
        bit match;
        hist.push_back(b);
        if (hist.size() > 6) void'(hist.pop_front());
        match = (hist.size() == 6) && hist[0] == 8'hF6 && hist[1] == 8'hF6 &&
                hist[2] == 8'hF6 && hist[3] == 8'h28 && hist[4] == 8'h28 &&
                hist[5] == 8'h28;
        pr = m_row;
        pc = m_col;
        if (m_state == 0) begin
            if (match) begin
                pr = 0; pc = 5; m_state = 1; m_good = 1;
            end
        end else if (pr == 0 && pc == 5) begin
            if (m_state == 1) begin
                if (match) begin
                    m_good++;
                    if (m_good >= 2) begin m_state = 2; m_lof = 0; m_bad = 0; end
                end else m_state = 0;
            end else begin
                if (match) m_bad = 0;
                else begin
                    m_bad++;
                    if (m_bad >= 4) begin m_state = 0; m_lof = 1; m_bad = 0; end
                end
            end
        end
        e_inf = (m_state == 2);
        e_lof = m_lof;
        e_valid = 1; e_byte = b; e_row = pr; e_col = pc;
        e_rs = e_inf && pc < 9 && pr < 3;
        e_ms = e_inf && pc < 9 && pr >= 4;
        e_sof = e_inf && pr == 0 && pc == 0;
        pc++;
        if (pc == 270) begin pc = 0; pr = (pr == 8) ? 0 : pr + 1; end
        m_row = pr; m_col = pc;
    endfunction

    task automatic drive(input bit v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_byte = b;
        if (v) model_step(b);
        else begin e_valid = 0; e_sof = 0; e_rs = 0; e_ms = 0; end
    endtask

    task automatic push(input logic [7:0] b);
        if ($urandom_range(0, 7) == 0) drive(0, 8'h5A);
        drive(1, b);
    endtask

    // Idle one cycle so the last byte's results are stable, then sample.
    task automatic settle();
        drive(0, 8'h00);
        @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] payload();
        logic [7:0] v = 8'($urandom);
        return (v == 8'hF6) ? 8'h00 : v;
    endfunction

    task automatic junk(input int n);
        for (int i = 0; i < n; i++) push(payload());
    endtask

    // One frame from position p0; corrupt breaks the middle 0x28 byte.
    task automatic frame_from(input int p0, input bit corrupt);
        for (int p = p0; p < FRAME_BYTES; p++) begin
            logic [7:0] b;
            if (p < 3) b = 8'hF6;
            else if (p < 6) b = (corrupt && p == 4) ? 8'h00 : 8'h28;
            else b = payload();
            push(b);
        end
    endtask

    // Per-clock comparison against the model (R2 R3 R6 R7 R8 R9).
    always @(posedge clk) begin
        if (mon_on && !finished) begin
            #1;
            check(out_valid == e_valid, "R9 out_valid", out_valid, e_valid);
            check(out_byte == 8'(e_byte), "R9 out_byte", out_byte, e_byte);
            check(row == 4'(e_row), "R2 row", row, e_row);
            check(col == 9'(e_col), "R2 col", col, e_col);
            check(in_frame == e_inf, "R3 in_frame", in_frame, e_inf);
            check(loss_of_frame == e_lof, "R6 loss_of_frame", loss_of_frame, e_lof);
            check(rs_oh == e_rs, "R7 rs_oh", rs_oh, e_rs);
            check(ms_oh == e_ms, "R7 ms_oh", ms_oh, e_ms);
            check(sof == e_sof, "R8 sof", sof, e_sof);
            if (sof) sof_seen++;
            if (rs_oh) rs_seen++;
            if (ms_oh) ms_seen++;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(posedge clk);
        #2;
        // R10: reset values
        check(out_valid == 0 && sof == 0 && rs_oh == 0 && ms_oh == 0, "R10 flags", out_valid, 0);
        check(row == 0 && col == 0, "R10 position", col, 0);
        check(in_frame == 0, "R10 in_frame", in_frame, 0);
        check(loss_of_frame == 0, "R10 loss_of_frame", loss_of_frame, 0);

        // R1: hunt finds the word at an arbitrary offset
        junk(500);
        for (int p = 0; p < 6; p++) push(p < 3 ? 8'hF6 : 8'h28);
        settle();
        check(row == 0 && col == 5, "R1 word end at col 5", col, 5);
        check(in_frame == 0, "R3 not after one word", in_frame, 0);
        frame_from(6, 0);
        settle();
        check(in_frame == 0, "R3 still confirming", in_frame, 0);
        frame_from(0, 0);
        settle();
        check(in_frame == 1, "R3 aligned after second word", in_frame, 1);

        // R7 R8: markers over one whole aligned frame
        sof_seen = 0; rs_seen = 0; ms_seen = 0;
        frame_from(0, 0);
        settle();
        check(sof_seen == 1, "R8 one pulse per frame", sof_seen, 1);
        check(rs_seen == 27, "R7 regenerator bytes", rs_seen, 27);
        check(ms_seen == 45, "R7 multiplex bytes", ms_seen, 45);

        // R5: three errored words are tolerated
        for (int f = 0; f < 3; f++) frame_from(0, 1);
        frame_from(0, 0);
        settle();
        check(in_frame == 1, "R5 rides through three errors", in_frame, 1);
        check(loss_of_frame == 0, "R5 no alarm", loss_of_frame, 0);

        // R6: four errored words drop alignment
        for (int f = 0; f < 4; f++) frame_from(0, 1);
        settle();
        check(in_frame == 0, "R6 alignment dropped", in_frame, 0);
        check(loss_of_frame == 1, "R6 alarm raised", loss_of_frame, 1);
        sof_seen = 0; rs_seen = 0; ms_seen = 0;
        junk(777);
        settle();
        check(rs_seen + ms_seen == 0, "R7 no markers while hunting", rs_seen + ms_seen, 0);
        check(sof_seen == 0, "R8 no pulse while hunting", sof_seen, 0);

        // R4: confirmation fails on an errored second word
        frame_from(0, 0);
        frame_from(0, 1);
        settle();
        check(in_frame == 0, "R4 back to hunt", in_frame, 0);
        check(loss_of_frame == 1, "R6 alarm held while hunting", loss_of_frame, 1);

        // R6: alarm clears on relock
        frame_from(0, 0);
        frame_from(0, 0);
        settle();
        check(in_frame == 1, "R3 relocked", in_frame, 1);
        check(loss_of_frame == 0, "R6 alarm cleared on relock", loss_of_frame, 0);

        repeat (3) @(posedge clk);
        summary();
    end

endmodule